// File: doc/BRIEF.md
# Pulse-Framed Synchronous Serial Master

This block is the master side of a synchronous serial link. It accepts words through a valid/ready handshake from a transmit queue, shifts each word out most significant bit first, and at the same time collects the bits that the far device returns into a right-justified receive word. It generates the serial clock from the system clock with a programmable divider. The clock runs only while a word is in flight.

The default framing marks the start of every word with a frame strobe. The strobe is high for one full serial clock period and begins on a rising edge, and the first data bit follows on the next rising edge. Both ends launch data on rising edges and capture it on falling edges. A mode input selects a select-style framing instead, in which the frame line is active low and held low for the whole transfer. When a frame ends and another word is already offered, that word starts at once. Otherwise the link goes quiet and a one-cycle done strobe is raised.

Top module: `tiss_master`

## Requirements
- R1: While idle, `sclk` is low and `txdOe` is low. `fss` is low when `spiMode`=0 and high when `spiMode`=1, and `sclk` does not toggle.
- R2: With `spiMode`=0, `fss` rises together with a rising edge of `sclk` before each word. It stays high for exactly one serial clock period and is low during every data bit.
- R3: With `spiMode`=1, `fss` is low from the first rising `sclk` edge of a transfer until the transfer returns to idle.
- R4: Each word is sent as `sizeSel`+1 bits, most significant first. The first bit is launched on the rising edge after the frame period, and each later bit on the following rising edges. `txdOe` rises on that first data edge and stays high until idle.
- R5: `rxd` is captured on falling `sclk` edges. After the last capture of a frame, `rxValid` is high for exactly one system cycle, and `rxData` then holds the received bits right-justified with zeros above.
- R6: One serial clock period lasts 2*`clkDiv` system cycles, with `clkDiv`=0 treated as 1. This spacing also holds across back-to-back frames.
- R7: If `txValid` is high at the rising-edge slot that ends a frame, a new frame period starts on that edge with no idle gap.
- R8: When no word is offered at the end of a frame, the block returns to idle and raises `txDone` for one system cycle.
- R9: `sizeSel` encodes the word length minus one (3 to 15 means 4 to 16 bits). Values 0 to 2 act as 3, and the size is taken at the start of each frame.
- R10: `txReady` is high in idle and in the slot that ends a frame, and low at all other times. A word is taken when `txValid` and `txReady` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiMode | input | 1 | 0: pulse framing, 1: active-low select framing |
| sizeSel | input | 4 | Word length minus one |
| clkDiv | input | 8 | Half serial period in system cycles |
| txValid | input | 1 | Transmit word offered |
| txData | input | 16 | Transmit word, right-justified |
| txReady | output | 1 | Transmit word accepted this cycle when valid |
| rxd | input | 1 | Serial receive line |
| rxData | output | 16 | Received word, right-justified |
| rxValid | output | 1 | One-cycle strobe for rxData |
| sclk | output | 1 | Serial clock |
| fss | output | 1 | Frame line |
| txd | output | 1 | Serial transmit data |
| txdOe | output | 1 | Output enable for txd |
| txDone | output | 1 | One-cycle strobe on return to idle |

## Verification
On every cycle the assertions check how the edges line up. The pulse frame strobe and the output enable may only rise with a rising serial edge. The receive strobe may only appear on a falling edge and lasts a single cycle. In select mode the clock is never high while the select is released. A taken word always starts a clock high phase, and the done strobe always coincides with idle pin levels. Only the bench scenarios can show that the bit order, the received word contents, the serial period, the width clamp and the unbroken chaining of queued words are right. These are observed through an emulated far device that returns known words.

// File: rtl/tiss_pkg.sv
package tiss_pkg;
  typedef struct packed {
    logic load;     // take a new word into the shifters
    logic shiftTx;  // launch next transmit bit
    logic capRx;    // capture receive bit
  } dpCtl_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FRAME = 2'd1,
    S_DATA  = 2'd2
  } state_t;
endpackage

// File: rtl/tiss_tick.sv
module tiss_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             tick
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    lim  = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
    tick = run && (cnt >= lim - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/tiss_datapath.sv
module tiss_datapath
  import tiss_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SIZE_W-1:0] sizeM1,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              txdReg;
  logic [SIZE_W-1:0] shAmt;

  assign shAmt  = SIZE_W'(DATA_W - 1) - sizeM1;
  assign txd    = txdReg;
  assign rxData = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      txdReg  <= 1'b0;
    end else begin
      if (ctl.load) begin
        txShift <= txData << shAmt;  // left-justify so the MSB leads
        rxShift <= '0;
      end else if (ctl.shiftTx) begin
        txdReg  <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (ctl.capRx) rxShift <= {rxShift[DATA_W-2:0], rxd};
    end
  end
endmodule

// File: rtl/tiss_control.sv
module tiss_control
  import tiss_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SIZE_W = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiMode,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              txValid,
  input  logic              tick,
  output logic              txReady,
  output logic              run,
  output logic [SIZE_W-1:0] loadSize,
  output dpCtl_t            ctl,
  output logic              sclk,
  output logic              fss,
  output logic              txdOe,
  output logic              rxValid,
  output logic              txDone
);
  state_t            state;
  logic [SIZE_W-1:0] sizeReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              pulse, modeReg;
  logic              riseTick, fallTick, allCaptured, endSlot, accept;

  always_comb begin
    loadSize    = (sizeSel < SIZE_W'(3)) ? SIZE_W'(3) : sizeSel;
    fallTick    = tick && sclk;
    riseTick    = tick && !sclk;
    allCaptured = (bitCnt == CNT_W'(sizeReg) + CNT_W'(1));
    endSlot     = (state == S_DATA) && riseTick && allCaptured;
    txReady     = (state == S_IDLE) || endSlot;
    accept      = txReady && txValid;
    run         = (state != S_IDLE);
    ctl.load    = accept;
    ctl.shiftTx = riseTick && ((state == S_FRAME) || ((state == S_DATA) && !allCaptured));
    ctl.capRx   = fallTick && (state == S_DATA);
    fss         = (state == S_IDLE) ? spiMode : (modeReg ? 1'b0 : pulse);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sizeReg <= '0;
      bitCnt  <= '0;
      pulse   <= 1'b0;
      modeReg <= 1'b0;
      sclk    <= 1'b0;
      txdOe   <= 1'b0;
      rxValid <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      txDone  <= 1'b0;
      if (accept) begin
        state   <= S_FRAME;
        sclk    <= 1'b1;
        pulse   <= 1'b1;
        modeReg <= spiMode;
        sizeReg <= loadSize;
        bitCnt  <= '0;
      end else begin
        case (state)
          S_FRAME: begin
            if (fallTick) sclk <= 1'b0;
            if (riseTick) begin
              sclk  <= 1'b1;
              pulse <= 1'b0;
              txdOe <= 1'b1;
              state <= S_DATA;
            end
          end
          S_DATA: begin
            if (fallTick) begin
              sclk   <= 1'b0;
              bitCnt <= bitCnt + CNT_W'(1);
              if (bitCnt == CNT_W'(sizeReg)) rxValid <= 1'b1;
            end
            if (riseTick) begin
              if (!allCaptured) sclk <= 1'b1;
              else begin
                state  <= S_IDLE;
                txdOe  <= 1'b0;
                txDone <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tiss_master.sv
module tiss_master
  import tiss_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiMode,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              sclk,
  output logic              fss,
  output logic              txd,
  output logic              txdOe,
  output logic              txDone
);
  dpCtl_t            ctl;
  logic              tick, run;
  logic [SIZE_W-1:0] loadSize;

  tiss_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rstN(rstN), .run(run), .clkDiv(clkDiv), .tick(tick)
  );

  tiss_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .sizeSel(sizeSel),
    .txValid(txValid), .tick(tick), .txReady(txReady), .run(run),
    .loadSize(loadSize), .ctl(ctl), .sclk(sclk), .fss(fss),
    .txdOe(txdOe), .rxValid(rxValid), .txDone(txDone)
  );

  tiss_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sizeM1(loadSize),
    .txData(txData), .rxd(rxd), .txd(txd), .rxData(rxData)
  );
endmodule

// File: rtl/tiss_master_chk.sv
module tiss_master_chk (
  input logic clk,
  input logic rstN,
  input logic spiMode,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic sclk,
  input logic fss,
  input logic txdOe,
  input logic txDone
);
  p_pulse_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!spiMode && $rose(fss)) |-> $rose(sclk));

  p_select_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (spiMode && sclk) |-> !fss);

  p_oe_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txdOe) |-> $rose(sclk));

  p_rx_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $fell(sclk));

  p_rx_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (!sclk && !txdOe && (fss == spiMode)));

  p_take_starts_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> sclk);
endmodule

bind tiss_master tiss_master_chk u_chk (
  .clk(clk), .rstN(rstN), .spiMode(spiMode), .txValid(txValid),
  .txReady(txReady), .rxValid(rxValid), .sclk(sclk), .fss(fss),
  .txdOe(txdOe), .txDone(txDone)
);

// File: tb/tiss_master_test.sv
`timescale 1ns/1ps
module tiss_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiMode = 1'b0;
  logic [3:0]  sizeSel = 4'd7;
  logic [7:0]  clkDiv = 8'd1;
  logic        txValid = 1'b0;
  logic [15:0] txData = '0;
  logic        rxd = 1'b0;
  logic        txReady, rxValid, sclk, fss, txd, txdOe, txDone;
  logic [15:0] rxData;

  always #5 clk = ~clk;

  tiss_master uut (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .sizeSel(sizeSel),
    .clkDiv(clkDiv), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxd(rxd), .rxData(rxData), .rxValid(rxValid), .sclk(sclk), .fss(fss),
    .txd(txd), .txdOe(txdOe), .txDone(txDone)
  );

  int nChk = 0, nFail = 0;
  int curSize = 8, curHalf = 1;
  bit curSpi = 0, monOn = 0;
  logic [15:0] txW [0:7];
  logic [15:0] slvW [0:7];
  int frameNo, rxNo, doneCnt, pos, idx, cyc;
  bit riseValid, prevSclk;
  logic [15:0] gotTx;

  function automatic logic [15:0] maskOf(int sz);
    return 16'((32'd1 << sz) - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // emulated far device and protocol monitor
  always @(negedge clk) if (monOn) begin
    cyc++;
    if (!prevSclk && sclk) begin
      if (riseValid) chk(cyc == 2*curHalf, "R6 serial period", cyc, 2*curHalf);
      riseValid = 1; cyc = 0;
      idx = pos;
      pos = (pos == curSize) ? 0 : pos + 1;
      if (idx == 0) begin
        if (curSpi) chk(fss == 1'b0, "R3 select at frame start", fss, 0);
        else        chk(fss == 1'b1, "R2 frame pulse", fss, 1);
      end else begin
        if (curSpi) chk(fss == 1'b0, "R3 select during data", fss, 0);
        else        chk(fss == 1'b0, "R2 pulse low during data", fss, 0);
        chk(txdOe == 1'b1, "R4 output enable", txdOe, 1);
        rxd = slvW[frameNo & 7][curSize - idx];
      end
    end
    if (prevSclk && !sclk && idx != 0) begin
      gotTx = {gotTx[14:0], txd};
      if (idx == curSize) begin
        chk((gotTx & maskOf(curSize)) == (txW[frameNo & 7] & maskOf(curSize)),
            "R4 transmit bits", gotTx & maskOf(curSize), txW[frameNo & 7] & maskOf(curSize));
        frameNo++;
      end
    end
    if (rxValid) begin
      chk(rxData == (slvW[rxNo & 7] & maskOf(curSize)), "R5 received word",
          rxData, slvW[rxNo & 7] & maskOf(curSize));
      chk(prevSclk && !sclk && idx == curSize, "R5 strobe after last capture", idx, curSize);
      rxNo++;
    end
    if (txDone) begin
      chk(!sclk && !txdOe && fss == curSpi, "R8 idle at done", {sclk, txdOe, fss}, {2'b00, curSpi});
      chk(pos == 0, "R8 frame complete", pos, 0);
      doneCnt++;
      riseValid = 0;
    end
    prevSclk = sclk;
  end

  task automatic pushWord(logic [15:0] d);
    txValid = 1'b1; txData = d;
    #1;
    while (!txReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic checkIdle(string tag);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!sclk && !txdOe && fss == curSpi, tag, {sclk, txdOe, fss}, {2'b00, curSpi});
    end
  endtask

  // n words back to back, sz bits, half period, framing mode, clamp probe
  task automatic runBurst(int n, int sz, int half, bit spi, bit clampProbe);
    @(negedge clk);
    curSize = sz; curHalf = half; curSpi = spi;
    spiMode = spi;
    clkDiv = (half == 1 && ($urandom % 2)) ? 8'd0 : 8'(half);
    sizeSel = clampProbe ? 4'($urandom % 3) : 4'(sz - 1);
    for (int i = 0; i < n; i++) begin
      txW[i] = 16'($urandom);
      slvW[i] = 16'($urandom);
    end
    frameNo = 0; rxNo = 0; doneCnt = 0; pos = 0; idx = 0; riseValid = 0;
    checkIdle("R1 idle levels before burst");
    for (int i = 0; i < n; i++) begin
      pushWord(txW[i]);
      if (i == 0) chk(txReady == 1'b0, "R10 not ready mid frame", txReady, 0);
    end
    for (int c = 0; c < 20000 && doneCnt == 0; c++) @(negedge clk);
    chk(doneCnt == 1, "R8 single done", doneCnt, 1);
    chk(frameNo == n, "R7 frames chained", frameNo, n);
    chk(rxNo == n, "R5 receive strobes", rxNo, n);
    if (clampProbe) chk(frameNo == n, "R9 clamped size", frameNo, n);
    checkIdle("R1 quiet after done");
    chk(txReady == 1'b1, "R10 ready in idle", txReady, 1);
  endtask

  initial begin
    #1900000;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!sclk && !txdOe && !fss && !rxValid && !txDone, "R1 reset state",
        {sclk, txdOe, fss, rxValid, txDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    prevSclk = sclk;
    monOn = 1;
    // directed corners
    runBurst(1, 8, 2, 0, 0);
    runBurst(1, 4, 1, 0, 0);   // R9 smallest size
    runBurst(1, 16, 3, 0, 0);  // R9 largest size
    runBurst(2, 4, 2, 0, 1);   // R9 clamp of sizeSel below 3
    runBurst(3, 8, 2, 0, 0);   // R7 chained frames
    runBurst(1, 12, 2, 1, 0);  // R3 select framing
    runBurst(3, 5, 1, 1, 0);   // R3 R7 select framing chained
    // constrained random
    for (int t = 0; t < 24; t++)
      runBurst(1 + int'($urandom % 4), 4 + int'($urandom % 13),
               1 + int'($urandom % 4), bit'($urandom % 2), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule